// File: doc/BRIEF.md
# Parallel host mailbox interface

This block is an 8-bit parallel slave port that an external host processor uses to swap bytes with an internal processor core. The host sees a small register file. It selects a register with two select lines, sets a read/write line, and frames each access with an active-low enable strobe. A write is latched when the strobe is released. A read puts the chosen register on the bidirectional bus from the moment the strobe is asserted until it is released. The bus is released whenever the strobe is inactive.

Bytes flow in both directions through two-stage mailboxes. A host write lands in a host-side transmit register and moves on to a core-side receive register as soon as that register is empty. A core load lands in a core-side transmit register and moves on to a host-side receive register once the host has emptied it. A status register lets the host poll the mailbox flags and two flags that the core sets. An enable register lets the host choose which flags drive the active-low request output, so the host can be interrupted. The request is withdrawn while the DMA acknowledge input is asserted.

The host pins are resynchronised to the block clock. A host access must therefore hold its strobe level, select lines, read/write line and write data for at least four clock cycles on each side of every strobe edge.

Top module: `hostmbx_top`

## Requirements
- R1: After a synchronous active-low reset, host_req_n is high, core_rx_full is 0, core_tx_empty is 1, the enable register reads 0x00, and the status register reads 0x06 while core_hflag is 0.
- R2: A host write to the data register (host_sel 2, host_rw 0) captures host_d at the rising edge of host_en_n. The byte then appears on core_rx_data with core_rx_full high, and stays there until core_take is pulsed.
- R3: During a host read (host_rw 1), the block drives the selected register onto host_d from the falling edge of host_en_n until its rising edge. While the strobe is inactive, host_d is left undriven.
- R4: The status register (host_sel 1) holds: bit 0 host receive register full, bit 1 host transmit register empty, bit 2 transfer ready, bits 3 and 4 equal to core_hflag[0] and core_hflag[1], bits 5 and 6 zero, and bit 7 set while the host request is asserted.
- R5: Transfer ready (status bit 2) is 1 only when both the host transmit register and the core-side receive register are empty. A host write made while the core-side register is full is held with status bit 1 at 0. It passes through once the core takes the earlier byte.
- R6: A core_load pulse with core_din moves the byte to the host receive register when that register is empty and sets status bit 0. A host read of the data register returns the byte and clears status bit 0 when the strobe rises.
- R7: The enable register (host_sel 0) is read and written by the host. Bit 0 enables the receive-full request and bit 1 enables the transmit-empty request. host_req_n is low when (bit 0 AND receive full) OR (bit 1 AND transmit empty).
- R8: Servicing clears the request. Reading the data register withdraws a receive-full request, and writing the data register while the core side is full withdraws a transmit-empty request.
- R9: Clearing the enable bit of the active source sets host_req_n high.
- R10: While dma_ack_n is low, host_req_n is high and status bit 7 reads 0. The request returns when dma_ack_n goes high again.
- R11: A reset in the middle of operation empties all mailbox registers, clears the enables and releases the request.
- R12: Host writes to the status register have no effect, and reads with host_sel 3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_d | inout | 8 | Host data bus |
| host_sel | input | 2 | Register select: 0 enable, 1 status, 2 data, 3 unused |
| host_rw | input | 1 | 1 = host read, 0 = host write |
| host_en_n | input | 1 | Active-low access strobe |
| dma_ack_n | input | 1 | Active-low DMA acknowledge; masks the request |
| host_req_n | output | 1 | Active-low host request |
| core_hflag | input | 2 | Application flags set by the core, shown in status bits 3 and 4 |
| core_load | input | 1 | One-cycle pulse: core writes core_din toward the host |
| core_din | input | 8 | Core byte toward the host |
| core_tx_empty | output | 1 | Core-side transmit register is empty |
| core_take | input | 1 | One-cycle pulse: core consumes core_rx_data |
| core_rx_data | output | 8 | Byte received from the host |
| core_rx_full | output | 1 | core_rx_data holds an unconsumed byte |

## Verification
Several properties are checked on every cycle. A byte in either receive register stays held until its consumer takes it. A host write into a fully empty path reaches the core register two cycles after the strobe edge is detected. The request is low in the cycle after a DMA acknowledge or after an all-zero enable register. The bus driver stays off once the strobe has been inactive for two sampled cycles. Other behaviours are shown only by the bench scenarios: the exact status byte layout, the held write while the core side is full, servicing a request by a data access, writes to the status register having no effect, and a reset in the middle of an exchange.

// File: rtl/hostmbx_pkg.sv
// Package: shared constants for the host mailbox interface.
// Assumes an 8-bit host data path; the status layout below fills one byte.
package hostmbx_pkg;
    localparam int SEL_W = 2;

    // host register select codes
    localparam logic [SEL_W-1:0] SEL_IEN  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_STAT = 2'd1;
    localparam logic [SEL_W-1:0] SEL_DATA = 2'd2;

    // status register bit positions (host decodes these)
    localparam int ST_RXF  = 0;
    localparam int ST_TXE  = 1;
    localparam int ST_TRDY = 2;
    localparam int ST_HF0  = 3;
    localparam int ST_HF1  = 4;
    localparam int ST_REQ  = 7;

    // enable register bit positions
    localparam int IEN_RX = 0;
    localparam int IEN_TX = 1;
    localparam int IEN_W  = 2;
endpackage

// File: rtl/hostmbx_strobe.sv
// Module: hostmbx_strobe
// Resynchronises the asynchronous host pins through SYNC_STAGES flops and
// turns the strobe into single-cycle begin/end events.
// Assumes the host holds select, direction and write data stable across
// each strobe edge for longer than the synchroniser delay.
module hostmbx_strobe #(
    parameter int DATA_W      = 8,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_en_n,
    input  logic              pin_rw,
    input  logic [SEL_W-1:0]  pin_sel,
    input  logic [DATA_W-1:0] pin_d,
    output logic              wr_pulse,
    output logic              rd_begin,
    output logic              rd_finish,
    output logic              rd_active,
    output logic              strobe_high,
    output logic              strobe_high_q,
    output logic [SEL_W-1:0]  acc_sel,
    output logic [DATA_W-1:0] acc_data
);
    localparam int PW = DATA_W + SEL_W + 2;
    localparam logic [PW-1:0] RST_V = PW'(1);   // strobe idle (high), rest zero

    logic [PW-1:0] pipe [SYNC_STAGES];
    logic [PW-1:0] pin_vec;
    logic          en_now, en_prev, rw_now, rise, fall;

    assign pin_vec = {pin_rw, pin_sel, pin_d, pin_en_n};

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            // first synchroniser stage samples the pins
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[i] <= RST_V;
                else        pipe[i] <= pin_vec;
            end
        end else begin : g_next
            // later stages shift the sampled pin word along
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[i] <= RST_V;
                else        pipe[i] <= pipe[i-1];
            end
        end
    end

    assign en_now   = pipe[SYNC_STAGES-1][0];
    assign acc_data = pipe[SYNC_STAGES-1][DATA_W:1];
    assign acc_sel  = pipe[SYNC_STAGES-1][DATA_W+SEL_W:DATA_W+1];
    assign rw_now   = pipe[SYNC_STAGES-1][PW-1];

    // previous strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) en_prev <= 1'b1;
        else        en_prev <= en_now;
    end

    assign rise      = en_now & ~en_prev;
    assign fall      = ~en_now & en_prev;
    assign wr_pulse  = rise & ~rw_now;
    assign rd_finish = rise & rw_now;
    assign rd_begin  = fall & rw_now;

    assign strobe_high   = en_now;
    assign strobe_high_q = en_prev;

    // read window: opens at the strobe fall of a read, closes at any rise
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_active <= 1'b0;
        else if (rise)     rd_active <= 1'b0;
        else if (rd_begin) rd_active <= 1'b1;
    end
endmodule

// File: rtl/hostmbx_regs.sv
// Module: hostmbx_regs
// Two-stage mailboxes in each direction with their handshake flags.
// Host->core: host transmit register, then core receive register.
// Core->host: core transmit register, then host receive register.
// Assumes host and core event pulses last exactly one clock.
module hostmbx_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_data,
    input  logic              host_rd_data,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              core_load,
    input  logic [DATA_W-1:0] core_din,
    input  logic              core_take,
    output logic [DATA_W-1:0] core_rx_data,
    output logic              core_rx_full,
    output logic              core_tx_empty,
    output logic [DATA_W-1:0] host_rx_data,
    output logic              rx_full,
    output logic              tx_empty,
    output logic              xfer_ready
);
    logic [DATA_W-1:0] htx_q, ctx_q;
    logic              htx_full, ctx_full, hrx_full, crx_full;
    logic              fwd_in, fwd_out;

    assign fwd_in  = htx_full & ~crx_full;   // host byte moves to core side
    assign fwd_out = ctx_full & ~hrx_full;   // core byte moves to host side

    // host transmit register: loaded by host data writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            htx_q    <= '0;
            htx_full <= 1'b0;
        end else begin
            if (host_wr_data) htx_q <= host_wdata;
            htx_full <= (htx_full & ~fwd_in) | host_wr_data;
        end
    end

    // core receive register: filled from host side, emptied by core_take
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_rx_data <= '0;
            crx_full     <= 1'b0;
        end else if (fwd_in) begin
            core_rx_data <= htx_q;
            crx_full     <= 1'b1;
        end else if (core_take) begin
            crx_full     <= 1'b0;
        end
    end

    // core transmit register: loaded by core_load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q    <= '0;
            ctx_full <= 1'b0;
        end else begin
            if (core_load) ctx_q <= core_din;
            ctx_full <= (ctx_full & ~fwd_out) | core_load;
        end
    end

    // host receive register: filled from core side, emptied by host read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rx_data <= '0;
            hrx_full     <= 1'b0;
        end else if (fwd_out) begin
            host_rx_data <= ctx_q;
            hrx_full     <= 1'b1;
        end else if (host_rd_data) begin
            hrx_full     <= 1'b0;
        end
    end

    assign core_rx_full  = crx_full;
    assign core_tx_empty = ~ctx_full;
    assign rx_full       = hrx_full;
    assign tx_empty      = ~htx_full;
    assign xfer_ready    = ~htx_full & ~crx_full;

    // R2
    crx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crx_full && !core_take |=> crx_full);

    // R6
    hrx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hrx_full && !host_rd_data |=> hrx_full);

    // R5
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_data && xfer_ready |=> ##1 crx_full);
endmodule

// File: rtl/hostmbx_req.sv
// Module: hostmbx_req
// Holds the host request enable register and forms the registered request:
// each source flag gated by its enable, withdrawn while DMA acknowledge is low.
// Assumes the enable write pulse is one clock long.
module hostmbx_req
    import hostmbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_wr,
    input  logic [IEN_W-1:0] ien_wdata,
    input  logic             rx_full,
    input  logic             tx_empty,
    input  logic             dma_ack_n,
    output logic [IEN_W-1:0] ien_q,
    output logic             req_q
);
    logic req_d;

    // enable register written by the host
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_wr) ien_q <= ien_wdata;
    end

    assign req_d = ((rx_full & ien_q[IEN_RX]) | (tx_empty & ien_q[IEN_TX])) & dma_ack_n;

    // registered request, low on reset
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    // R10
    dma_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_ack_n |=> !req_q);

    // R9
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ien_q == '0 && !ien_wr |=> !req_q);
endmodule

// File: rtl/hostmbx_top.sv
// Module: hostmbx_top
// Parallel host mailbox interface: host register decode, read snapshot and
// tri-state bus driver around the strobe, mailbox and request units.
// Assumes DATA_W = 8 (status byte layout) and a host that meets the
// hold time set by SYNC_STAGES.
module hostmbx_top
    import hostmbx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    inout  wire  [DATA_W-1:0] host_d,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic              host_rw,
    input  logic              host_en_n,
    input  logic              dma_ack_n,
    output logic              host_req_n,
    input  logic [1:0]        core_hflag,
    input  logic              core_load,
    input  logic [DATA_W-1:0] core_din,
    output logic              core_tx_empty,
    input  logic              core_take,
    output logic [DATA_W-1:0] core_rx_data,
    output logic              core_rx_full
);
    logic              wr_pulse, rd_begin, rd_finish, rd_active;
    logic              strobe_high, strobe_high_q;
    logic [SEL_W-1:0]  acc_sel;
    logic [DATA_W-1:0] acc_data, host_rx_data, rd_mux, rd_q, stat_byte;
    logic              rx_full, tx_empty, xfer_ready, req_q;
    logic [IEN_W-1:0]  ien_q;
    logic              wr_data_ev, rd_data_ev, wr_ien_ev;

    hostmbx_strobe #(
        .DATA_W(DATA_W), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_strobe (
        .clk(clk), .rst_n(rst_n),
        .pin_en_n(host_en_n), .pin_rw(host_rw), .pin_sel(host_sel), .pin_d(host_d),
        .wr_pulse(wr_pulse), .rd_begin(rd_begin), .rd_finish(rd_finish),
        .rd_active(rd_active), .strobe_high(strobe_high), .strobe_high_q(strobe_high_q),
        .acc_sel(acc_sel), .acc_data(acc_data)
    );

    assign wr_data_ev = wr_pulse  & (acc_sel == SEL_DATA);
    assign wr_ien_ev  = wr_pulse  & (acc_sel == SEL_IEN);
    assign rd_data_ev = rd_finish & (acc_sel == SEL_DATA);

    hostmbx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr_data(wr_data_ev), .host_rd_data(rd_data_ev), .host_wdata(acc_data),
        .core_load(core_load), .core_din(core_din), .core_take(core_take),
        .core_rx_data(core_rx_data), .core_rx_full(core_rx_full),
        .core_tx_empty(core_tx_empty), .host_rx_data(host_rx_data),
        .rx_full(rx_full), .tx_empty(tx_empty), .xfer_ready(xfer_ready)
    );

    hostmbx_req u_req (
        .clk(clk), .rst_n(rst_n),
        .ien_wr(wr_ien_ev), .ien_wdata(acc_data[IEN_W-1:0]),
        .rx_full(rx_full), .tx_empty(tx_empty), .dma_ack_n(dma_ack_n),
        .ien_q(ien_q), .req_q(req_q)
    );

    // status byte assembled from the flags
    always_comb begin
        stat_byte          = '0;
        stat_byte[ST_RXF]  = rx_full;
        stat_byte[ST_TXE]  = tx_empty;
        stat_byte[ST_TRDY] = xfer_ready;
        stat_byte[ST_HF0]  = core_hflag[0];
        stat_byte[ST_HF1]  = core_hflag[1];
        stat_byte[ST_REQ]  = req_q;
    end

    // host read decode
    always_comb begin
        case (acc_sel)
            SEL_IEN:  rd_mux = DATA_W'(ien_q);
            SEL_STAT: rd_mux = stat_byte;
            SEL_DATA: rd_mux = host_rx_data;
            default:  rd_mux = '0;
        endcase
    end

    // snapshot of the read value taken at the strobe fall
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_q <= '0;
        else if (rd_begin) rd_q <= rd_mux;
    end

    assign host_d     = rd_active ? rd_q : {DATA_W{1'bz}};
    assign host_req_n = ~req_q;

    // R3
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_high && strobe_high_q |-> !rd_active);

    // R4
    stat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active && acc_sel == SEL_STAT |-> rd_q[6:5] == 2'b00);
endmodule

// File: tb/sim_hostmbx_top.sv
module sim_hostmbx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic       host_rw = 1'b1;
    logic       host_en_n = 1'b1;
    logic       dma_ack_n = 1'b1;
    logic       host_req_n;
    logic [1:0] core_hflag = 2'b00;
    logic       core_load = 1'b0;
    logic [7:0] core_din = 8'h00;
    logic       core_tx_empty;
    logic       core_take = 1'b0;
    logic [7:0] core_rx_data;
    logic       core_rx_full;
    logic       bus_oe = 1'b0;
    logic [7:0] bus_val = 8'h00;
    wire  [7:0] host_d;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    assign host_d = bus_oe ? bus_val : 8'bzzzzzzzz;

    always #10 clk = ~clk;   // 50 MHz

    hostmbx_top u0 (
        .clk(clk), .rst_n(rst_n), .host_d(host_d), .host_sel(host_sel),
        .host_rw(host_rw), .host_en_n(host_en_n), .dma_ack_n(dma_ack_n),
        .host_req_n(host_req_n), .core_hflag(core_hflag), .core_load(core_load),
        .core_din(core_din), .core_tx_empty(core_tx_empty), .core_take(core_take),
        .core_rx_data(core_rx_data), .core_rx_full(core_rx_full)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [7:0] v);
        @(negedge clk);
        host_sel = sel; host_rw = 1'b0; bus_val = v; bus_oe = 1'b1;
        idle(1);
        host_en_n = 1'b0;
        idle(5);
        host_en_n = 1'b1;
        idle(5);
        bus_oe = 1'b0; host_rw = 1'b1;
        idle(2);
    endtask

    task automatic host_read(input logic [1:0] sel, output logic [7:0] v);
        @(negedge clk);
        host_sel = sel; host_rw = 1'b1;
        idle(1);
        host_en_n = 1'b0;
        idle(6);
        v = host_d;
        host_en_n = 1'b1;
        idle(6);
    endtask

    task automatic core_push(input logic [7:0] v);
        @(negedge clk);
        core_din = v; core_load = 1'b1;
        @(negedge clk);
        core_load = 1'b0;
        idle(3);
    endtask

    task automatic core_pop(input string req, input logic [7:0] exp);
        @(negedge clk);
        chk(req, {7'd0, core_rx_full}, 8'h01);
        chk(req, core_rx_data, exp);
        core_take = 1'b1;
        @(negedge clk);
        core_take = 1'b0;
        idle(3);
    endtask

    // vector: op[23:22] (0 host write, 1 host read+check, 2 core load, 3 core take+check),
    //         sel[21:20], data[19:12], expected[11:4], requirement number[3:0]
    localparam int NV = 20;
    localparam logic [23:0] VEC [NV] = '{
        {2'd1, 2'd1, 8'h00, 8'h06, 4'd4},  // R4 idle status
        {2'd0, 2'd0, 8'h01, 8'h00, 4'd7},  // R7 enable receive request
        {2'd1, 2'd0, 8'h00, 8'h01, 4'd7},  // R7 read back enables
        {2'd2, 2'd0, 8'h3C, 8'h00, 4'd6},  // R6 core sends 3C
        {2'd1, 2'd1, 8'h00, 8'h87, 4'd6},  // R6 rx full, request set
        {2'd1, 2'd2, 8'h00, 8'h3C, 4'd6},  // R6 host reads byte
        {2'd1, 2'd1, 8'h00, 8'h06, 4'd8},  // R8 read withdrew request
        {2'd0, 2'd2, 8'h5A, 8'h00, 4'd2},  // R2 host sends 5A
        {2'd1, 2'd1, 8'h00, 8'h02, 4'd5},  // R5 core side full: no transfer ready
        {2'd0, 2'd2, 8'hC3, 8'h00, 4'd5},  // R5 second byte held
        {2'd1, 2'd1, 8'h00, 8'h00, 4'd5},  // R5 both stages full
        {2'd3, 2'd0, 8'h00, 8'h5A, 4'd2},  // R2 core takes 5A
        {2'd1, 2'd1, 8'h00, 8'h02, 4'd5},  // R5 held byte passed through
        {2'd3, 2'd0, 8'h00, 8'hC3, 4'd5},  // R5 core takes C3
        {2'd1, 2'd1, 8'h00, 8'h06, 4'd5},  // R5 all empty again
        {2'd0, 2'd1, 8'hFF, 8'h00, 4'd12}, // R12 write to status
        {2'd1, 2'd1, 8'h00, 8'h06, 4'd12}, // R12 status unchanged
        {2'd1, 2'd3, 8'h00, 8'h00, 4'd12}, // R12 unused select reads zero
        {2'd0, 2'd0, 8'h02, 8'h00, 4'd7},  // R7 enable transmit request
        {2'd1, 2'd1, 8'h00, 8'h86, 4'd7}   // R7 tx empty raises request
    };

    initial begin : main
        logic [7:0] v;
        idle(4);
        rst_n = 1'b1;
        idle(3);
        // R1 reset state
        chk("R1 req_n", {7'd0, host_req_n}, 8'h01);
        chk("R1 rx_full", {7'd0, core_rx_full}, 8'h00);
        chk("R1 tx_empty", {7'd0, core_tx_empty}, 8'h01);
        host_read(2'd0, v); chk("R1 enables", v, 8'h00);
        host_read(2'd1, v); chk("R1 status", v, 8'h06);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
            case (VEC[i][23:22])
                2'd0: host_write(VEC[i][21:20], VEC[i][19:12]);
                2'd1: begin host_read(VEC[i][21:20], v); chk(tag, v, VEC[i][11:4]); end
                2'd2: core_push(VEC[i][19:12]);
                default: core_pop(tag, VEC[i][11:4]);
            endcase
        end

        // R7 transmit-empty request on the pin
        chk("R7 req pin", {7'd0, host_req_n}, 8'h00);
        // R10 DMA acknowledge withdraws request
        @(negedge clk); dma_ack_n = 1'b0; idle(3);
        chk("R10 req pin", {7'd0, host_req_n}, 8'h01);
        host_read(2'd1, v); chk("R10 status", v, 8'h06);
        @(negedge clk); dma_ack_n = 1'b1; idle(3);
        chk("R10 released", {7'd0, host_req_n}, 8'h00);
        // R8 write servicing: fill core side, then hold a byte
        host_write(2'd2, 8'h77);
        chk("R8 still requesting", {7'd0, host_req_n}, 8'h00);
        host_write(2'd2, 8'h88);
        chk("R8 req cleared by write", {7'd0, host_req_n}, 8'h01);
        host_read(2'd1, v); chk("R8 status", v, 8'h00);
        // R4 core flags in bits 3 and 4
        @(negedge clk); core_hflag = 2'b11; idle(2);
        host_read(2'd1, v); chk("R4 flags", v, 8'h18);
        @(negedge clk); core_hflag = 2'b00; idle(2);
        // R9 masking
        core_pop("R2 take 77", 8'h77);
        chk("R9 request back", {7'd0, host_req_n}, 8'h00);
        host_write(2'd0, 8'h00);
        chk("R9 masked", {7'd0, host_req_n}, 8'h01);
        // R8 read servicing
        host_write(2'd0, 8'h01);
        chk("R8 no rx yet", {7'd0, host_req_n}, 8'h01);
        core_push(8'h99);
        chk("R8 rx request", {7'd0, host_req_n}, 8'h00);
        host_read(2'd2, v); chk("R6 data 99", v, 8'h99);
        chk("R8 req cleared by read", {7'd0, host_req_n}, 8'h01);
        // R3 bus released while strobe idle
        @(negedge clk); bus_val = 8'hA5; bus_oe = 1'b1; idle(2);
        chk("R3 bus idle", host_d, 8'hA5);
        @(negedge clk); bus_oe = 1'b0; idle(2);
        // R11 reset mid-operation
        host_write(2'd2, 8'h44);
        core_push(8'h12);
        host_write(2'd0, 8'h03);
        chk("R11 pre req", {7'd0, host_req_n}, 8'h00);
        @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(3);
        chk("R11 req", {7'd0, host_req_n}, 8'h01);
        chk("R11 core rx", {7'd0, core_rx_full}, 8'h00);
        chk("R11 core tx", {7'd0, core_tx_empty}, 8'h01);
        host_read(2'd1, v); chk("R11 status", v, 8'h06);
        host_read(2'd0, v); chk("R11 enables", v, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule